// File: doc/BRIEF.md
# Reed-Solomon Symbol-to-Byte Error Patcher

The patcher sits after a 12-bit-symbol Reed-Solomon decoder. It takes the decoder's error list and applies it to a byte-addressed page buffer held in a dual-port memory. The buffer is linear. Bytes 0 to 2047 are the page data, and spare byte k sits at address 2048+k. Symbols are packed at one and a half bytes each, so a symbol can cover two bytes and can cross from the data region into the spare region. Symbol 0 is a partial symbol and covers a single byte.

The decoder presents a stream of beats with a valid/ready handshake. A beat is either one error pair (symbol position, 12-bit pattern) or an end-of-page marker. For each good pair the block performs one or two read-modify-write XOR updates on the memory, taking one byte at a time. A pair that cannot be applied marks the page as failed and does not touch the memory. When the end marker arrives, the block reports the number of corrected symbols, or raises the failure flag. It then clears its per-page state.

Top module: `rs_byte_patcher`

## Requirements
- R1: A pair whose position exceeds 1374 marks the page as failed and causes no memory read or write.
- R2: At position 0, a pattern with any of bits 11:8 set marks the page as failed and writes nothing. Otherwise byte 0 is XORed with pattern bits 7:0 in one read-modify-write.
- R3: At an odd position p, byte floor(3p/2) is XORed with pattern bits 11:4, and byte floor(3p/2)+1 is XORed with {pattern bits 3:0, 4'b0000}.
- R4: At an even nonzero position p, byte 3p/2-1 is XORed with {4'b0000, pattern bits 11:8}, and byte 3p/2 is XORed with pattern bits 7:0.
- R5: Addressing is linear across the two regions. Position 1365 puts pattern bits 11:4 into data byte 2047 and pattern bits 3:0 into the high nibble of spare byte 0 (address 2048). Positions 1366 to 1374 land in spare bytes under the rules of R3 and R4.
- R6: Each byte update is a read strobe in one cycle, then a write to the same address in the next cycle, carrying the read data XOR the correction. The lower address of a pair is updated first.
- R7: pair_ready_o drops after a pair is accepted and stays low until its last write. That is 2 cycles for a one-byte pair, 4 cycles for a two-byte pair, and 0 cycles for a failing pair.
- R8: At most 4 pairs are applied per page. Any further pair marks the page as failed and is not applied.
- R9: In the cycle after an end marker is accepted, result_valid_o pulses for one cycle. corr_cnt_o then holds the number of applied pairs if the page did not fail, or 0 with fail_o=1 if it failed. The per-page count and failure are then cleared.
- R10: After reset, pair_ready_o is 1, mem_re_o, mem_we_o, result_valid_o and fail_o are 0, and corr_cnt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pair_valid_i | input | 1 | Beat valid |
| pair_ready_o | output | 1 | Beat accepted when high with valid |
| pair_end_i | input | 1 | Beat is an end-of-page marker (position and pattern ignored) |
| pair_pos_i | input | 11 | Symbol position |
| pair_pat_i | input | 12 | Error pattern |
| mem_re_o | output | 1 | Buffer read strobe |
| mem_raddr_o | output | 12 | Buffer read address |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_waddr_o | output | 12 | Buffer write address |
| mem_wdata_o | output | 8 | Buffer write data |
| result_valid_o | output | 1 | One-cycle pulse after an end marker |
| corr_cnt_o | output | 3 | Corrected symbol count for the last page |
| fail_o | output | 1 | Last page was uncorrectable |

## Verification
The case that is hardest to reach from the ports is two corrections landing on the same byte. It happens when an odd position and the even position after it share their middle byte, or when position 1365 and position 1366 both touch spare address 2048. The byte is only right if the second read sees the first write. The stimulus sends such adjacent pairs back to back, compares the shared byte against hand-computed values, and compares the whole buffer against a reference. Overflow is reached by a page with five good pairs. The last pair's bytes must stay unchanged.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } rmw_state_e;

  // Decoded correction for one symbol: up to two adjacent bytes
  typedef struct packed {
    logic       bad;
    logic       two;
    logic [7:0] xv_lo;
    logic [7:0] xv_hi;
  } patch_t;

endpackage

// File: rtl/rsp_map.sv
module rsp_map
  import rsp_pkg::*;
#(
  parameter int SYM_W   = 12,
  parameter int POS_W   = 11,
  parameter int ADDR_W  = 12,
  parameter int MAX_POS = 1374
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] addr_o,
  output patch_t            patch_o
);

  localparam int NIB_W = SYM_W - 8;

  logic [POS_W+1:0]  tri_pos;
  logic [ADDR_W-1:0] half_pos;
  logic              out_of_range;
  logic              is_zero;

  assign tri_pos      = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
  assign half_pos     = ADDR_W'(tri_pos >> 1);
  assign out_of_range = pos_i > POS_W'(MAX_POS);
  assign is_zero      = pos_i == '0;

  always_comb begin
    addr_o  = half_pos;
    patch_o = '0;
    if (out_of_range) begin
      patch_o.bad = 1'b1;
    end else if (is_zero) begin
      // partial symbol: only the low byte maps to data
      addr_o        = '0;
      patch_o.bad   = |pat_i[SYM_W-1:8];
      patch_o.xv_lo = pat_i[7:0];
    end else if (pos_i[0]) begin
      patch_o.two   = 1'b1;
      patch_o.xv_lo = pat_i[SYM_W-1 -: 8];
      patch_o.xv_hi = {pat_i[NIB_W-1:0], {(8-NIB_W){1'b0}}};
    end else begin
      addr_o        = half_pos - ADDR_W'(1);
      patch_o.two   = 1'b1;
      patch_o.xv_lo = {{(8-NIB_W){1'b0}}, pat_i[SYM_W-1:8]};
      patch_o.xv_hi = pat_i[7:0];
    end
  end

endmodule

// File: rtl/rsp_rmw.sv
module rsp_rmw
  import rsp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 2112
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  patch_t            patch_i,
  output logic              busy_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [7:0]        rdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o
);

  rmw_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        xv_q;
  logic [7:0]        xv_next_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      xv_q      <= '0;
      xv_next_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q    <= addr_i;
            xv_q      <= patch_i.xv_lo;
            xv_next_q <= patch_i.xv_hi;
            pend_q    <= patch_i.two;
            state_q   <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (pend_q) begin
            addr_q  <= addr_q + ADDR_W'(1);
            xv_q    <= xv_next_q;
            pend_q  <= 1'b0;
            state_q <= ST_RD;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = state_q != ST_IDLE;
  assign re_o    = state_q == ST_RD;
  assign raddr_o = addr_q;
  assign we_o    = state_q == ST_WR;
  assign waddr_o = addr_q;
  assign wdata_o = rdata_i ^ xv_q;

  AST_WE_AFTER_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(re_o) && (waddr_o == $past(raddr_o))); // R6
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R7
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |-> (int'(raddr_o) < DEPTH)); // R5

endmodule

// File: rtl/rsp_tally.sv
module rsp_tally #(
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic             end_i,
  output logic             full_o,
  output logic             result_valid_o,
  output logic [CNT_W-1:0] corr_cnt_o,
  output logic             fail_o
);

  logic [CNT_W-1:0] acc_cnt_q;
  logic             acc_fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_q      <= '0;
      acc_fail_q     <= 1'b0;
      result_valid_o <= 1'b0;
      corr_cnt_o     <= '0;
      fail_o         <= 1'b0;
    end else begin
      result_valid_o <= end_i;
      if (end_i) begin
        fail_o     <= acc_fail_q;
        corr_cnt_o <= acc_fail_q ? '0 : acc_cnt_q;
        acc_cnt_q  <= '0;
        acc_fail_q <= 1'b0;
      end else begin
        if (good_i) acc_cnt_q  <= acc_cnt_q + CNT_W'(1);
        if (bad_i)  acc_fail_q <= 1'b1;
      end
    end
  end

  assign full_o = acc_cnt_q == CNT_W'(MAX_ERR);

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(acc_cnt_q) <= MAX_ERR); // R8
  AST_FAIL_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && fail_o) |-> (corr_cnt_o == '0)); // R9

endmodule

// File: rtl/rs_byte_patcher.sv
module rs_byte_patcher
  import rsp_pkg::*;
#(
  parameter int SYM_W       = 12,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_POS     = 1374,
  parameter int MAX_ERR     = 4,
  localparam int DEPTH      = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int POS_W      = $clog2(MAX_POS + 1),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_valid_i,
  output logic              pair_ready_o,
  input  logic              pair_end_i,
  input  logic [POS_W-1:0]  pair_pos_i,
  input  logic [SYM_W-1:0]  pair_pat_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              result_valid_o,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic              fail_o
);

  logic              busy;
  logic              accept;
  logic              take_pair;
  logic              take_end;
  logic              full;
  logic              fail_ev;
  logic              start;
  logic [ADDR_W-1:0] map_addr;
  patch_t            map_patch;

  assign pair_ready_o = !busy;
  assign accept       = pair_valid_i && pair_ready_o;
  assign take_pair    = accept && !pair_end_i;
  assign take_end     = accept && pair_end_i;
  assign fail_ev      = take_pair && (map_patch.bad || full);
  assign start        = take_pair && !map_patch.bad && !full;

  rsp_map #(
    .SYM_W  (SYM_W),
    .POS_W  (POS_W),
    .ADDR_W (ADDR_W),
    .MAX_POS(MAX_POS)
  ) u_map (
    .pos_i  (pair_pos_i),
    .pat_i  (pair_pat_i),
    .addr_o (map_addr),
    .patch_o(map_patch)
  );

  rsp_rmw #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_rmw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .addr_i (map_addr),
    .patch_i(map_patch),
    .busy_o (busy),
    .re_o   (mem_re_o),
    .raddr_o(mem_raddr_o),
    .rdata_i(mem_rdata_i),
    .we_o   (mem_we_o),
    .waddr_o(mem_waddr_o),
    .wdata_o(mem_wdata_o)
  );

  rsp_tally #(
    .MAX_ERR(MAX_ERR),
    .CNT_W  (CNT_W)
  ) u_tally (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .good_i        (start),
    .bad_i         (fail_ev),
    .end_i         (take_end),
    .full_o        (full),
    .result_valid_o(result_valid_o),
    .corr_cnt_o    (corr_cnt_o),
    .fail_o        (fail_o)
  );

  AST_BAD_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_ev |=> !mem_re_o && !mem_we_o); // R1
  AST_READY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !pair_ready_o); // R7

endmodule

// File: tb/tb_rs_byte_patcher.sv
module tb_rs_byte_patcher;

  localparam int DEPTH = 2112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_valid = 1'b0;
  logic        pair_ready;
  logic        pair_end = 1'b0;
  logic [10:0] pair_pos = '0;
  logic [11:0] pair_pat = '0;
  logic        mem_re;
  logic [11:0] mem_raddr;
  logic [7:0]  mem_rdata = '0;
  logic        mem_we;
  logic [11:0] mem_waddr;
  logic [7:0]  mem_wdata;
  logic        result_valid;
  logic [2:0]  corr_cnt;
  logic        fail;

  always #5 clk = ~clk;

  rs_byte_patcher dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .pair_valid_i  (pair_valid),
    .pair_ready_o  (pair_ready),
    .pair_end_i    (pair_end),
    .pair_pos_i    (pair_pos),
    .pair_pat_i    (pair_pat),
    .mem_re_o      (mem_re),
    .mem_raddr_o   (mem_raddr),
    .mem_rdata_i   (mem_rdata),
    .mem_we_o      (mem_we),
    .mem_waddr_o   (mem_waddr),
    .mem_wdata_o   (mem_wdata),
    .result_valid_o(result_valid),
    .corr_cnt_o    (corr_cnt),
    .fail_o        (fail)
  );

  logic [7:0] mem     [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int pair_err = 0;
  int order_err = 0;
  logic        prev_re = 1'b0;
  logic [11:0] prev_raddr = '0;
  logic [11:0] last_waddr = '0;
  logic        in_pair = 1'b0;

  function automatic logic [7:0] init_byte(int i);
    return 8'(i * 7 + 3);
  endfunction

  // buffer model: one-cycle read, write port
  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mem[mem_raddr];
      rd_cnt = rd_cnt + 1;
    end
    if (mem_we) begin
      mem[mem_waddr] <= mem_wdata;
      wr_cnt = wr_cnt + 1;
      if (!prev_re || prev_raddr != mem_waddr) pair_err = pair_err + 1;
      if (in_pair && mem_waddr != last_waddr + 12'd1) order_err = order_err + 1;
      last_waddr = mem_waddr;
      in_pair = 1'b1;
    end
    if (pair_ready) in_pair = 1'b0;
    prev_re = mem_re;
    prev_raddr = mem_raddr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_apply(input int p, input logic [11:0] pat);
    int b;
    b = (3 * p) / 2;
    if (p == 0) exp_mem[0] ^= pat[7:0];
    else if (p % 2 == 1) begin
      exp_mem[b]     ^= pat[11:4];
      exp_mem[b + 1] ^= {pat[3:0], 4'h0};
    end else begin
      exp_mem[b - 1] ^= {4'h0, pat[11:8]};
      exp_mem[b]     ^= pat[7:0];
    end
  endtask

  task automatic cmp_mem(input string req);
    int nbad = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== exp_mem[i]) begin
        nbad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, $sformatf("%s buffer@%0d", req, first), int'(mem[first]), int'(exp_mem[first]));
  endtask

  task automatic send_pair(input int p, input logic [11:0] pat, output int busy);
    @(negedge clk);
    pair_valid = 1'b1;
    pair_end   = 1'b0;
    pair_pos   = 11'(p);
    pair_pat   = pat;
    while (!pair_ready) @(negedge clk);
    @(negedge clk);
    pair_valid = 1'b0;
    busy = 0;
    while (!pair_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic send_end(output bit rv, output int cnt, output bit fl, output bit rv_next);
    @(negedge clk);
    pair_valid = 1'b1;
    pair_end   = 1'b1;
    while (!pair_ready) @(negedge clk);
    @(negedge clk);
    pair_valid = 1'b0;
    pair_end   = 1'b0;
    rv  = result_valid;
    cnt = int'(corr_cnt);
    fl  = fail;
    @(negedge clk);
    rv_next = result_valid;
  endtask

  task automatic end_page(input int exp_cnt, input bit exp_fail, input string req);
    bit rv, fl, rvn;
    int cnt;
    send_end(rv, cnt, fl, rvn);
    chk(rv == 1'b1 && rvn == 1'b0, {req, " result pulse"}, {rv, rvn}, 2'b10);
    chk(cnt == exp_cnt, {req, " count"}, cnt, exp_cnt);
    chk(fl == exp_fail, {req, " fail"}, fl, exp_fail);
  endtask

  task automatic t_reset;
    chk(pair_ready == 1'b1, "R10 ready", pair_ready, 1);
    chk(!mem_re && !mem_we, "R10 mem idle", {mem_re, mem_we}, 0);
    chk(!result_valid && !fail && corr_cnt == 0, "R10 result idle",
        {result_valid, fail, corr_cnt}, 0);
  endtask

  task automatic t_pos_zero;
    int busy, w0;
    w0 = wr_cnt;
    send_pair(0, 12'h05A, busy);
    ref_apply(0, 12'h05A);
    chk(mem[0] == (init_byte(0) ^ 8'h5A), "R2 byte0", mem[0], init_byte(0) ^ 8'h5A);
    chk(wr_cnt - w0 == 1, "R2 single write", wr_cnt - w0, 1);
    chk(busy == 2, "R7 one-byte busy", busy, 2);
    w0 = wr_cnt;
    send_pair(0, 12'h15A, busy);
    chk(wr_cnt - w0 == 0 && busy == 0, "R2 wide pattern no write", wr_cnt - w0, 0);
    chk(mem[0] == (init_byte(0) ^ 8'h5A), "R2 byte0 kept", mem[0], init_byte(0) ^ 8'h5A);
    end_page(0, 1'b1, "R2 page");
  endtask

  task automatic t_odd_even;
    int busy;
    send_pair(1, 12'hABC, busy);
    ref_apply(1, 12'hABC);
    chk(busy == 4, "R7 two-byte busy", busy, 4);
    chk(mem[1] == (init_byte(1) ^ 8'hAB), "R3 odd upper", mem[1], init_byte(1) ^ 8'hAB);
    send_pair(2, 12'h123, busy);
    ref_apply(2, 12'h123);
    chk(mem[2] == (init_byte(2) ^ 8'hC0 ^ 8'h01), "R4 shared byte", mem[2],
        init_byte(2) ^ 8'hC0 ^ 8'h01);
    chk(mem[3] == (init_byte(3) ^ 8'h23), "R4 even low", mem[3], init_byte(3) ^ 8'h23);
    send_pair(681, 12'hFFF, busy);
    ref_apply(681, 12'hFFF);
    chk(mem[1021] == (init_byte(1021) ^ 8'hFF) && mem[1022] == (init_byte(1022) ^ 8'hF0),
        "R3 mid page", mem[1022], init_byte(1022) ^ 8'hF0);
    cmp_mem("R3 R4 buffer");
    chk(pair_err == 0, "R6 read-then-write pairing", pair_err, 0);
    chk(order_err == 0, "R6 lower byte first", order_err, 0);
    end_page(3, 1'b0, "R9 good page");
  endtask

  task automatic t_boundary;
    int busy;
    send_pair(1365, 12'h9A5, busy);
    ref_apply(1365, 12'h9A5);
    chk(mem[2047] == (init_byte(2047) ^ 8'h9A), "R5 data last byte", mem[2047],
        init_byte(2047) ^ 8'h9A);
    chk(mem[2048] == (init_byte(2048) ^ 8'h50), "R5 spare first nibble", mem[2048],
        init_byte(2048) ^ 8'h50);
    send_pair(1366, 12'h3C7, busy);
    ref_apply(1366, 12'h3C7);
    chk(mem[2048] == (init_byte(2048) ^ 8'h50 ^ 8'h03), "R5 spare shared", mem[2048],
        init_byte(2048) ^ 8'h53);
    send_pair(1374, 12'h777, busy);
    ref_apply(1374, 12'h777);
    chk(mem[2060] == (init_byte(2060) ^ 8'h07) && mem[2061] == (init_byte(2061) ^ 8'h77),
        "R5 last position", mem[2061], init_byte(2061) ^ 8'h77);
    cmp_mem("R5 buffer");
    end_page(3, 1'b0, "R5 page");
  endtask

  task automatic t_range;
    int busy, r0;
    r0 = rd_cnt;
    send_pair(1375, 12'h001, busy);
    send_pair(2047, 12'hFFF, busy);
    chk(rd_cnt - r0 == 0 && busy == 0, "R1 no access", rd_cnt - r0, 0);
    cmp_mem("R1 buffer");
    end_page(0, 1'b1, "R1 page");
  endtask

  task automatic t_overflow;
    int busy;
    send_pair(10, 12'h111, busy); ref_apply(10, 12'h111);
    send_pair(21, 12'h222, busy); ref_apply(21, 12'h222);
    send_pair(30, 12'h333, busy); ref_apply(30, 12'h333);
    send_pair(41, 12'h444, busy); ref_apply(41, 12'h444);
    send_pair(50, 12'h555, busy);
    chk(busy == 0, "R8 fifth not started", busy, 0);
    chk(mem[74] == init_byte(74) && mem[75] == init_byte(75), "R8 fifth bytes kept",
        mem[75], init_byte(75));
    cmp_mem("R8 buffer");
    end_page(0, 1'b1, "R8 page");
  endtask

  task automatic t_clear;
    int busy;
    send_pair(100, 12'h0F0, busy);
    ref_apply(100, 12'h0F0);
    end_page(1, 1'b0, "R9 cleared after fail");
    end_page(0, 1'b0, "R9 empty page");
    cmp_mem("R9 buffer");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = init_byte(i);
      exp_mem[i] = init_byte(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pos_zero();
    t_odd_even();
    t_boundary();
    t_range();
    t_overflow();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule